// File: doc/BRIEF.md
# Two-Way Write-Back Set-Associative Cache

This block sits between a CPU that issues single-word loads and stores and a memory controller that moves whole cache lines. It keeps 8 KB of data in two ways of 256 sets each, with 16-byte lines. On a miss it allocates a line for both loads and stores. Modified lines stay in the cache until they are displaced, and are then written out in full. Byte-masked stores are merged into the cached line, so every memory transfer is a complete line and the memory side never needs a byte mask.

The CPU port is a valid/ready port. The CPU raises `cpu_valid` with a word-aligned address, direction, write data and byte strobes, and holds all of them unchanged until `cpu_ready` pulses high for one cycle. Until then the cache accepts nothing new, and that wait is the CPU's back-pressure. The memory port uses the same holding rule. `mem_req` stays high with a stable line address, direction and line data until `mem_ack` is high for one cycle, and on a read the line is taken in that cycle. The memory may take any number of cycles to answer. Every access has a fixed cost. Cycle 0 is the cycle in which the idle cache first sees `cpu_valid`, and an access of cost N raises `cpu_ready` in cycle N-1. R and W are the number of cycles between the first cycle of a read or write-back request and its acknowledge.

Top module: `wbc_cache2w`

## Requirements
- R1: After reset, `cpu_ready` and `mem_req` are low, every line is invalid and every set's LRU bit is 0, so the first access to any address misses.
- R2: Address bits [11:4] select the set, bits [3:2] select the word and bits [31:12] form the tag. Word i of a line travels on line-data bits [32i+31:32i].
- R3: A read that hits costs 2 cycles, returns the cached word on `cpu_rdata` together with `cpu_ready`, and makes no memory request.
- R4: A write that hits costs 2 cycles and makes no memory request. Strobe bit b replaces bits [8b+7:8b] of the word, the other bytes keep their values, and the line becomes dirty.
- R5: A read miss whose victim is clean or invalid costs 4+R cycles: one line read, then the requested word.
- R6: A write miss whose victim is clean or invalid costs 5+R cycles. The line is filled first and the strobed bytes are merged in the next cycle.
- R7: A miss whose victim is dirty costs 12+W+R cycles for a read and 13+W+R cycles for a write: one line write-back followed by one line fill.
- R8: The victim is an invalid way if there is one, with way 0 checked before way 1. Otherwise it is the way named by the set's LRU bit. Every hit and every fill sets that bit to the other way.
- R9: Memory is written only when a dirty line is evicted. The whole line is written and includes every merged byte. Clean victims are dropped without a write.
- R10: A memory request holds its address, direction and write data until acknowledged, and its address has the low 4 bits zero.
- R11: CPU addresses are word-aligned. `cpu_ready` is a one-cycle pulse, and on a read `cpu_rdata` is valid in that cycle.
- R12: While `cpu_valid` is low the cache stays idle: no `cpu_ready` and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU request present, held until `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address, word-aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Byte strobes for a store |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| mem_req | output | 1 | Line transfer request, held until `mem_ack` |
| mem_ack | input | 1 | Transfer complete, one cycle |
| mem_we | output | 1 | 1 for a line write-back, 0 for a line fill |
| mem_addr | output | 32 | Line address, low 4 bits zero |
| mem_wdata | output | 128 | Line being written back |
| mem_rdata | input | 128 | Fill line, taken when `mem_ack` is high |

## Verification
In the cycle of a write hit, three things happen together: the byte merge into the data array, the LRU update and the setting of the dirty bit. In the cycle a fill is acknowledged, the new line, tag and valid bit are written together with an LRU update. The bench provokes these coincidences with sequences where a masked store hits a set and later misses to the same set force evictions. It judges them by the cycle cost of each later access, which shows whether the right way was chosen and whether it was dirty, and by the words read back. It also checks that every written-back line matches the byte-accurate image the bench keeps, and that the number of write-backs equals the number of dirty evictions predicted by its own model of tags and LRU.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_EVICT, ST_WB, ST_SETTLE, ST_FILL, ST_MERGE, ST_DONE
  } wbc_state_e;
endpackage

// File: rtl/wbc_tags.sv
`timescale 1ns/1ps
module wbc_tags #(
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       hit_vec,
  output logic             vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic             dset_en,
  input  logic             dset_way,
  input  logic             dclr_en,
  input  logic             dclr_way
);
  logic [1:0]       way_val;
  logic [1:0]       way_dirty;
  logic [TAG_W-1:0] way_tag [2];
  logic [SETS-1:0]  lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_r [SETS];
    logic [SETS-1:0]  val_r;
    logic [SETS-1:0]  dirty_r;

    assign way_val[w]   = val_r[idx];
    assign way_dirty[w] = dirty_r[idx];
    assign way_tag[w]   = tag_r[idx];
    assign hit_vec[w]   = val_r[idx] && (tag_r[idx] == tag);

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_r[idx] <= tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_r   <= '0;
        dirty_r <= '0;
      end else begin
        if (fill_en && fill_way == 1'(w)) begin
          val_r[idx]   <= 1'b1;
          dirty_r[idx] <= 1'b0;
        end
        if (dset_en && dset_way == 1'(w)) dirty_r[idx] <= 1'b1;
        if (dclr_en && dclr_way == 1'(w)) dirty_r[idx] <= 1'b0;
      end
    end
  end

  // invalid way first (way 0 before way 1), otherwise the least recently used one
  assign vic_way   = !way_val[0] ? 1'b0 : (!way_val[1] ? 1'b1 : lru_q[idx]);
  assign vic_dirty = way_val[vic_way] && way_dirty[vic_way];
  assign vic_tag   = way_tag[vic_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q      <= '0;
    else if (fill_en)  lru_q[idx] <= ~fill_way;
    else if (touch_en) lru_q[idx] <= ~touch_way;
  end

  assert_onehot_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/wbc_data.sv
`timescale 1ns/1ps
module wbc_data #(
  parameter int SETS   = 256,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 2,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rd_way,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [31:0]       rd_data,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic              ln_en,
  input  logic              ln_way,
  input  logic [IDX_W-1:0]  ln_idx,
  input  logic [LINE_W-1:0] ln_data
);
  localparam int DEPTH = 2 * SETS * WORDS;

  logic [31:0] store_q [DEPTH];

  assign rd_data = store_q[{rd_way, rd_idx, rd_word}];

  always_ff @(posedge clk) begin
    if (ln_en) begin
      for (int i = 0; i < WORDS; i++)
        store_q[{ln_way, ln_idx, WSEL_W'(i)}] <= ln_data[32*i +: 32];
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++)
        if (wr_be[b]) store_q[{wr_way, wr_idx, wr_word}][8*b +: 8] <= wr_data[8*b +: 8];
    end
  end
endmodule

// File: rtl/wbc_cache2w.sv
`timescale 1ns/1ps
module wbc_cache2w #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int WORDS  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [31:0]         cpu_wdata,
  input  logic [3:0]          cpu_be,
  output logic [31:0]         cpu_rdata,
  output logic                mem_req,
  input  logic                mem_ack,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [32*WORDS-1:0] mem_wdata,
  input  logic [32*WORDS-1:0] mem_rdata
);
  import wbc_pkg::*;

  localparam int IDX_W  = $clog2(SETS);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 32 * WORDS;
  localparam int CNT_W  = $clog2(WORDS + 1);

  wbc_state_e         st;
  logic               rq_we;
  logic [ADDR_W-1:2]  rq_addr;
  logic [31:0]        rq_wdata;
  logic [3:0]         rq_be;
  logic               vic_way_q;
  logic [TAG_W-1:0]   vic_tag_q;
  logic [CNT_W-1:0]   cnt;
  logic [LINE_W-1:0]  wb_buf;

  logic [TAG_W-1:0]   req_tag;
  logic [IDX_W-1:0]   req_idx;
  logic [WSEL_W-1:0]  req_word;
  logic [1:0]         hit_vec;
  logic               hit;
  logic               vic_way;
  logic               vic_dirty;
  logic [TAG_W-1:0]   vic_tag;
  logic               rd_way;
  logic [WSEL_W-1:0]  rd_word;
  logic [31:0]        rd_data;
  logic               touch_en;
  logic               fill_en;
  logic               dset_en;
  logic               dset_way;
  logic               dclr_en;

  assign req_tag  = rq_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = rq_addr[OFF_W +: IDX_W];
  assign req_word = rq_addr[2 +: WSEL_W];
  assign hit      = |hit_vec;

  assign touch_en = (st == ST_LOOK) && hit;
  assign fill_en  = (st == ST_FILL) && mem_ack;
  assign dset_en  = (touch_en && rq_we) || (st == ST_MERGE);
  assign dset_way = (st == ST_LOOK) ? hit_vec[1] : vic_way_q;
  assign dclr_en  = (st == ST_WB) && mem_ack;

  assign rd_way   = (st == ST_LOOK) ? hit_vec[1] : vic_way_q;
  assign rd_word  = (st == ST_EVICT) ? WSEL_W'(cnt - CNT_W'(1)) : req_word;

  assign cpu_ready = touch_en || (st == ST_DONE);
  assign cpu_rdata = rd_data;
  assign mem_req   = (st == ST_WB) || (st == ST_FILL);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = {(st == ST_WB) ? vic_tag_q : req_tag, req_idx, OFF_W'(0)};
  assign mem_wdata = wb_buf;

  wbc_tags #(.SETS(SETS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(req_idx), .tag(req_tag),
    .hit_vec(hit_vec), .vic_way(vic_way), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .touch_en(touch_en), .touch_way(hit_vec[1]),
    .fill_en(fill_en), .fill_way(vic_way_q),
    .dset_en(dset_en), .dset_way(dset_way),
    .dclr_en(dclr_en), .dclr_way(vic_way_q)
  );

  wbc_data #(.SETS(SETS), .WORDS(WORDS), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .LINE_W(LINE_W)) u_data (
    .clk(clk), .rd_way(rd_way), .rd_idx(req_idx), .rd_word(rd_word), .rd_data(rd_data),
    .wr_en(dset_en), .wr_way(dset_way), .wr_idx(req_idx), .wr_word(req_word),
    .wr_be(rq_be), .wr_data(rq_wdata),
    .ln_en(fill_en), .ln_way(vic_way_q), .ln_idx(req_idx), .ln_data(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      rq_we     <= 1'b0;
      rq_addr   <= '0;
      rq_wdata  <= '0;
      rq_be     <= '0;
      vic_way_q <= 1'b0;
      vic_tag_q <= '0;
      cnt       <= '0;
      wb_buf    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (cpu_valid) begin
          rq_we    <= cpu_we;
          rq_addr  <= cpu_addr[ADDR_W-1:2];
          rq_wdata <= cpu_wdata;
          rq_be    <= cpu_be;
          st       <= ST_LOOK;
        end
        ST_LOOK: if (hit) st <= ST_IDLE;
          else begin
            vic_way_q <= vic_way;
            vic_tag_q <= vic_tag;
            cnt       <= '0;
            st        <= vic_dirty ? ST_EVICT : ST_FILL;
          end
        ST_EVICT: begin
          // one setup cycle, then one word of the victim per cycle
          if (cnt != '0) wb_buf[{rd_word, 5'b0} +: 32] <= rd_data;
          if (cnt == CNT_W'(WORDS)) st <= ST_WB;
          else cnt <= cnt + CNT_W'(1);
        end
        ST_WB:     if (mem_ack) st <= ST_SETTLE;
        ST_SETTLE: st <= ST_LOOK;
        ST_FILL:   if (mem_ack) st <= rq_we ? ST_MERGE : ST_DONE;
        ST_MERGE:  st <= ST_DONE;
        ST_DONE:   st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assert_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> cpu_addr[1:0] == 2'b00);
  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  assert_lookup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && cpu_valid) |=> !mem_req);
  assert_fill_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL && mem_ack) |=> hit_vec[vic_way_q]);
  assert_ready_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_req);
endmodule

// File: tb/wbc_cache2w_bench.sv
`timescale 1ns/1ps
module wbc_cache2w_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_ready;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [3:0]   cpu_be = '0;
  logic [31:0]  cpu_rdata;
  logic         mem_req;
  logic         mem_ack = 1'b0;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;

  wbc_cache2w u_wbc_cache2w (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int rlat = 2, wlat = 1, wait_cnt = 0;
  int acks = 0, wbs = 0, exp_wbs = 0;
  logic [127:0] mem  [2048];
  logic [127:0] arch [2048];
  logic [19:0]  mtag [2][256];
  bit           mv [2][256];
  bit           md [2][256];
  bit           mlru [256];

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // memory model: answers each request after rlat / wlat extra cycles
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= (mem_we ? wlat : rlat)) begin
        wait_cnt = 0;
        mem_ack = 1'b1;
        acks++;
        chk(mem_addr[3:0] == 4'h0 && mem_addr[31:15] == '0, "R10 line address", 128'(mem_addr), 128'(mem_addr & 32'h7FF0));
        if (mem_we) begin
          mem[mem_addr[14:4]] = mem_wdata;
          wbs++;
        end else mem_rdata = mem[mem_addr[14:4]];
      end else wait_cnt++;
    end
  end

  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd, input logic [3:0] be);
    logic [7:0]  idx = addr[11:4];
    logic [19:0] tg = addr[31:12];
    logic [10:0] ln = addr[14:4];
    int          ws = int'(addr[3:2]);
    int          exp_lat, exp_acks, k, a0, v;
    bit          hit = 0, dirty_ev = 0;
    logic [10:0] vline = '0;
    string       tag;
    for (int w = 0; w < 2; w++)
      if (mv[w][idx] && mtag[w][idx] == tg) begin hit = 1; v = w; end
    if (hit) begin
      exp_lat = 2; exp_acks = 0;
      tag = we ? "R4 write hit" : "R3 read hit";
      mlru[idx] = (v == 0);
      if (we) md[v][idx] = 1;
    end else begin
      v = !mv[0][idx] ? 0 : (!mv[1][idx] ? 1 : int'(mlru[idx]));
      dirty_ev = mv[v][idx] && md[v][idx];
      vline = {mtag[v][idx][2:0], idx};
      exp_lat = (dirty_ev ? 12 + wlat + rlat : 4 + rlat) + (we ? 1 : 0);
      exp_acks = dirty_ev ? 2 : 1;
      tag = dirty_ev ? "R7 R8 dirty miss" : (we ? "R6 R8 write miss" : "R5 R8 read miss");
      mtag[v][idx] = tg; mv[v][idx] = 1; md[v][idx] = we; mlru[idx] = (v == 0);
      if (dirty_ev) exp_wbs++;
    end
    if (we) for (int b = 0; b < 4; b++)
      if (be[b]) arch[ln][32*ws + 8*b +: 8] = wd[8*b +: 8];
    @(negedge clk);
    a0 = acks;
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; cpu_be = be;
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (cpu_ready || k > 2000) break;
    end
    chk(k + 1 == exp_lat, {tag, " latency"}, 128'(k + 1), 128'(exp_lat));
    if (!we) chk(cpu_rdata == arch[ln][32*ws +: 32], "R2 R11 read data", 128'(cpu_rdata), 128'(arch[ln][32*ws +: 32]));
    chk(acks - a0 == exp_acks, "R4 R9 memory transfers per access", 128'(acks - a0), 128'(exp_acks));
    if (dirty_ev) chk(mem[vline] == arch[vline], "R9 written-back line", mem[vline], arch[vline]);
    cpu_valid = 1'b0;
  endtask

  // {we, be, addr[15:0], wdata}
  localparam int NV = 18;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 4'h0, 16'h0050, 32'h0},        {1'b0, 4'h0, 16'h0054, 32'h0},
    {1'b1, 4'hF, 16'h0058, 32'h11112222}, {1'b0, 4'h0, 16'h0058, 32'h0},
    {1'b0, 4'h0, 16'h1050, 32'h0},        {1'b1, 4'h3, 16'h2050, 32'hAABBCCDD},
    {1'b0, 4'h0, 16'h0058, 32'h0},        {1'b0, 4'h0, 16'h2050, 32'h0},
    {1'b1, 4'h8, 16'h1234, 32'h77665544}, {1'b0, 4'h0, 16'h1234, 32'h0},
    {1'b1, 4'h1, 16'h3050, 32'h000000EE}, {1'b0, 4'h0, 16'h1050, 32'h0},
    {1'b0, 4'h0, 16'h2054, 32'h0},        {1'b0, 4'h0, 16'h2050, 32'h0},
    {1'b1, 4'h6, 16'h005C, 32'h12345678}, {1'b0, 4'h0, 16'h005C, 32'h0},
    {1'b1, 4'hF, 16'h7FF0, 32'hDEADBEEF}, {1'b0, 4'h0, 16'h7FF0, 32'h0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit quiet;
    for (int i = 0; i < 2048; i++) begin
      for (int j = 0; j < 4; j++) mem[i][32*j +: 32] = 32'(i * 16 + j * 4) ^ 32'hC3C30000;
      arch[i] = mem[i];
    end
    for (int s = 0; s < 256; s++) begin
      mv[0][s] = 0; mv[1][s] = 0; md[0][s] = 0; md[1][s] = 0; mlru[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready && !mem_req, "R1 reset outputs", {126'b0, cpu_ready, mem_req}, 128'b0);

    for (int i = 0; i < NV; i++)
      access(VEC[i][52], {16'h0, VEC[i][47:32]}, VEC[i][31:0], VEC[i][51:48]);

    // zero-latency memory: clean write miss, fill second way, dirty read miss
    rlat = 0; wlat = 0;
    access(1'b1, 32'h0090, 32'hCAFEF00D, 4'hF);
    access(1'b1, 32'h1094, 32'h0BADC0DE, 4'h5);
    access(1'b0, 32'h2090, 32'h0, 4'h0);
    // slow memory: dirty write miss then reads of every displaced line
    rlat = 5; wlat = 3;
    access(1'b1, 32'h3098, 32'h89ABCDEF, 4'hC);
    access(1'b0, 32'h0090, 32'h0, 4'h0);
    access(1'b0, 32'h1094, 32'h0, 4'h0);
    access(1'b0, 32'h3098, 32'h0, 4'h0);

    // idle window with no request
    quiet = 1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (cpu_ready || mem_req) quiet = 0;
    end
    chk(quiet, "R12 idle without request", 128'(!quiet), 128'(0));
    chk(wbs == exp_wbs, "R9 write-back count", 128'(wbs), 128'(exp_wbs));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule